// File: doc/BRIEF.md
# Register-Write Sequencer Program Encoder

This block assembles a compact, byte-coded program for a hardware register-write sequencer. It accepts a stream of requests over a valid/ready interface. Each request is one of four kinds: a register write carrying an address and a data word, a set-flag, a wait-on-flag, or a delay given in nanoseconds. Every request becomes one to ten command bytes. The bytes are appended, one per clock, to an internal program buffer that packs them into 32-bit words. The buffer can be read word by word through a plain read port.

The encoder keeps the last address and the last data word it emitted. A write whose data matches the remembered data emits no data command. When only the low half of a value changes, the encoder uses a 3-byte short form instead of the 5-byte long form.

Pulsing `finish_i` closes the program. The block reports the program length in words, which always includes at least one trailing filler byte. It then either pulses `exec_go` or raises `prog_overflow` when the length exceeds the capacity `CAP_WORDS`. Pulsing `clear_i` starts a new program.

Back-pressure works as follows:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` then stays low while the command bytes are written, one per cycle.
- `req_ready` is also low during `clear_i`.
- The request fields must stay stable while `req_valid` is high and `req_ready` is low.
- `finish_i` is acted on only while no command is being written.

Top module: `regseq_encoder`

## Requirements
- R1: After reset or a `clear_i` pulse, the following hold:
  - every buffer byte reads 0x7F;
  - `prog_words` is 0, `prog_overflow` is 0 and `req_ready` is 1;
  - the remembered address and data are all ones, so the next write uses the long forms.
- R2: A write request (`req_kind`=0) first emits a data command, but only if `req_data` differs from the remembered data.
  - If bits 31:16 match the remembered data, the command is 0x42 followed by data bits 7:0 and then bits 15:8.
  - Otherwise it is 0xE2 followed by the four data bytes, least significant first.
- R3: The address command always follows the data command.
  - If bits 31:16 match the remembered address, it is 0x40 followed by address bits 7:0 and then bits 15:8.
  - Otherwise it is 0xE0 followed by the four address bytes, least significant first.
  - After the write, the remembered address and data take the request's values.
- R4: A set-flag request (`req_kind`=1) emits one byte: 0x80 plus `req_flag`, plus 0x20 if the signed `req_val` is 0 or more, plus another 0x20 if it is 1 or more. For flag 3 this gives 0x83 for -1, 0xA3 for 0 and 0xC3 for 1.
- R5: A wait request (`req_kind`=2) emits three bytes: 0x5F, then `req_flag`, then `req_val`.
- R6: A delay request (`req_kind`=3) emits one byte, built in three steps:
  - divide `req_data` (nanoseconds) by 1000, truncate, and keep only the low 8 bits of the result;
  - while the count exceeds 3, shift it right by 2 and increment a shift count;
  - emit (shift << 2) | count.
- R7: Command bytes occupy consecutive buffer positions in issue order. Buffer word i, read on `rd_word` when `rd_idx`=i, holds bytes 4i to 4i+3, with byte 4i in bits 7:0.
- R8: A `finish_i` pulse sets `prog_words` to (bytes + 4) / 4 one cycle later. If that value is at most `CAP_WORDS`, `exec_go` pulses high for exactly that cycle.
- R9: If the word count exceeds `CAP_WORDS`, `prog_overflow` is set and `exec_go` stays low. Bytes beyond the buffer's 4*`CAP_WORDS` positions are counted but not stored.
- R10: After a request of N bytes is accepted, `req_ready` stays low for exactly N cycles, one byte being written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Start a new program |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_kind | input | 2 | 0 write, 1 set flag, 2 wait, 3 delay |
| req_addr | input | 32 | Register address for a write |
| req_data | input | 32 | Write data, or delay in nanoseconds |
| req_flag | input | 8 | Flag number |
| req_val | input | 8 | Signed flag value or expected value |
| finish_i | input | 1 | Close the program and evaluate its size |
| rd_idx | input | $clog2(CAP_WORDS) | Buffer word index to read |
| rd_word | output | 32 | Buffer word at `rd_idx` |
| prog_words | output | $clog2(4*CAP_WORDS)+2 | Program length in words from the last finish |
| exec_go | output | 1 | One-cycle pulse: program fits and may run |
| prog_overflow | output | 1 | Program exceeds capacity |

## Verification
The bench builds the block with `CAP_WORDS` set to 8, which gives a 32-byte buffer. With that size, a handful of long writes reaches the capacity. A 31-byte program (8 words, accepted) and a 32-byte program (9 words, rejected) then sit one delay request apart, so both sides of the boundary are checked. The full buffer is also read back in a few reads.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_SETF  = 2'd1,
    KIND_WAIT  = 2'd2,
    KIND_DELAY = 2'd3
  } req_kind_e;

  localparam int MAX_CMD_BYTES = 10;
  localparam int LEN_W         = 4;

  localparam logic [7:0] OP_DATA_SHORT = 8'h42;
  localparam logic [7:0] OP_DATA_LONG  = 8'hE2;
  localparam logic [7:0] OP_ADDR_SHORT = 8'h40;
  localparam logic [7:0] OP_ADDR_LONG  = 8'hE0;
  localparam logic [7:0] OP_SETF_BASE  = 8'h80;
  localparam logic [7:0] OP_SETF_STEP  = 8'h20;
  localparam logic [7:0] OP_WAIT       = 8'h5F;
  localparam logic [7:0] FILL_BYTE     = 8'h7F;

  localparam logic [31:0] NS_PER_US = 32'd1000;

  // Delay byte: microseconds kept to 8 bits, then scaled by powers of four.
  function automatic logic [7:0] delay_code(input logic [31:0] ns);
    logic [31:0] us_full;
    logic [7:0]  cnt;
    logic [1:0]  sh;
    us_full = ns / NS_PER_US;
    cnt     = us_full[7:0];
    sh      = 2'd0;
    for (int i = 0; i < 3; i++) begin
      if (cnt > 8'd3) begin
        cnt = cnt >> 2;
        sh  = sh + 2'd1;
      end
    end
    return {4'b0000, sh, cnt[1:0]};
  endfunction
endpackage

// File: rtl/regseq_cmd_build.sv
module regseq_cmd_build
  import regseq_pkg::*;
(
  input  logic [1:0]                         kind,
  input  logic [31:0]                        addr,
  input  logic [31:0]                        data,
  input  logic [7:0]                         flag,
  input  logic [7:0]                         val,
  input  logic [31:0]                        last_addr,
  input  logic [31:0]                        last_data,
  output logic [MAX_CMD_BYTES-1:0][7:0]      cmd_bytes,
  output logic [LEN_W-1:0]                   cmd_len
);
  logic [LEN_W-1:0] n;
  logic [7:0]       setf_byte;

  always_comb begin
    setf_byte = OP_SETF_BASE + flag;
    if (!val[7])            setf_byte = setf_byte + OP_SETF_STEP;
    if (!val[7] && val != 8'd0) setf_byte = setf_byte + OP_SETF_STEP;
  end

  always_comb begin
    cmd_bytes = '0;
    n         = '0;
    unique case (req_kind_e'(kind))
      KIND_WRITE: begin
        if (data != last_data) begin
          if (data[31:16] == last_data[31:16]) begin
            cmd_bytes[0] = OP_DATA_SHORT;
            cmd_bytes[1] = data[7:0];
            cmd_bytes[2] = data[15:8];
            n = 4'd3;
          end else begin
            cmd_bytes[0] = OP_DATA_LONG;
            cmd_bytes[1] = data[7:0];
            cmd_bytes[2] = data[15:8];
            cmd_bytes[3] = data[23:16];
            cmd_bytes[4] = data[31:24];
            n = 4'd5;
          end
        end
        if (addr[31:16] == last_addr[31:16]) begin
          cmd_bytes[n]        = OP_ADDR_SHORT;
          cmd_bytes[n + 4'd1] = addr[7:0];
          cmd_bytes[n + 4'd2] = addr[15:8];
          n = n + 4'd3;
        end else begin
          cmd_bytes[n]        = OP_ADDR_LONG;
          cmd_bytes[n + 4'd1] = addr[7:0];
          cmd_bytes[n + 4'd2] = addr[15:8];
          cmd_bytes[n + 4'd3] = addr[23:16];
          cmd_bytes[n + 4'd4] = addr[31:24];
          n = n + 4'd5;
        end
      end
      KIND_SETF: begin
        cmd_bytes[0] = setf_byte;
        n = 4'd1;
      end
      KIND_WAIT: begin
        cmd_bytes[0] = OP_WAIT;
        cmd_bytes[1] = flag;
        cmd_bytes[2] = val;
        n = 4'd3;
      end
      KIND_DELAY: begin
        cmd_bytes[0] = delay_code(data);
        n = 4'd1;
      end
      default: n = '0;
    endcase
  end

  assign cmd_len = n;
endmodule

// File: rtl/regseq_emitter.sv
module regseq_emitter
  import regseq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [MAX_CMD_BYTES-1:0][7:0] in_bytes,
  input  logic [LEN_W-1:0]              in_len,
  output logic                          wr_en,
  output logic [7:0]                    wr_byte
);
  logic                          busy;
  logic [LEN_W-1:0]              idx;
  logic [LEN_W-1:0]              len;
  logic [MAX_CMD_BYTES-1:0][7:0] hold;

  assign in_ready = !busy && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      busy <= 1'b0;
      idx  <= '0;
      len  <= '0;
      hold <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        hold <= in_bytes;
        len  <= in_len;
        idx  <= '0;
        busy <= (in_len != '0);
      end
    end else begin
      idx <= idx + 4'd1;
      if (idx == len - 4'd1) busy <= 1'b0;
    end
  end

  assign wr_en   = busy;
  assign wr_byte = hold[idx];
endmodule

// File: rtl/regseq_prog_buf.sv
module regseq_prog_buf
  import regseq_pkg::*;
#(
  parameter int CAP_WORDS = 64,
  localparam int BUF_BYTES = 4 * CAP_WORDS,
  localparam int BUF_AW    = $clog2(BUF_BYTES),
  localparam int WORD_W    = $clog2(CAP_WORDS),
  localparam int CNT_W     = BUF_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [7:0]        wr_byte,
  input  logic [WORD_W-1:0] rd_idx,
  output logic [31:0]       rd_word,
  output logic [CNT_W-1:0]  byte_cnt
);
  logic [7:0] mem [BUF_BYTES];
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= FILL_BYTE;
    end else if (wr_en) begin
      if (cnt < CNT_W'(BUF_BYTES)) mem[cnt[BUF_AW-1:0]] <= wr_byte;
      if (cnt != {CNT_W{1'b1}}) cnt <= cnt + 1'b1;
    end
  end

  generate
    for (genvar b = 0; b < 4; b++) begin : g_lane
      assign rd_word[8*b +: 8] = mem[{rd_idx, 2'(b)}];
    end
  endgenerate

  assign byte_cnt = cnt;
endmodule

// File: rtl/regseq_encoder.sv
module regseq_encoder
  import regseq_pkg::*;
#(
  parameter int CAP_WORDS = 64,
  localparam int BUF_BYTES = 4 * CAP_WORDS,
  localparam int BUF_AW    = $clog2(BUF_BYTES),
  localparam int WORD_W    = $clog2(CAP_WORDS),
  localparam int CNT_W     = BUF_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_data,
  input  logic [7:0]        req_flag,
  input  logic [7:0]        req_val,
  input  logic              finish_i,
  input  logic [WORD_W-1:0] rd_idx,
  output logic [31:0]       rd_word,
  output logic [CNT_W-1:0]  prog_words,
  output logic              exec_go,
  output logic              prog_overflow
);
  logic [31:0]                   last_addr, last_data;
  logic [MAX_CMD_BYTES-1:0][7:0] cmd_bytes;
  logic [LEN_W-1:0]              cmd_len;
  logic                          wr_en;
  logic [7:0]                    wr_byte;
  logic [CNT_W-1:0]              byte_cnt;
  logic [CNT_W-1:0]              words_now;
  logic                          accept;

  assign accept = req_valid && req_ready;

  regseq_cmd_build u_build (
    .kind      (req_kind),
    .addr      (req_addr),
    .data      (req_data),
    .flag      (req_flag),
    .val       (req_val),
    .last_addr (last_addr),
    .last_data (last_data),
    .cmd_bytes (cmd_bytes),
    .cmd_len   (cmd_len)
  );

  regseq_emitter u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear_i),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_bytes (cmd_bytes),
    .in_len   (cmd_len),
    .wr_en    (wr_en),
    .wr_byte  (wr_byte)
  );

  regseq_prog_buf #(.CAP_WORDS(CAP_WORDS)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear_i),
    .wr_en    (wr_en),
    .wr_byte  (wr_byte),
    .rd_idx   (rd_idx),
    .rd_word  (rd_word),
    .byte_cnt (byte_cnt)
  );

  // Remembered values start at all ones so the first write takes long forms.
  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      last_addr <= '1;
      last_data <= '1;
    end else if (accept && req_kind_e'(req_kind) == KIND_WRITE) begin
      last_addr <= req_addr;
      last_data <= req_data;
    end
  end

  assign words_now = (byte_cnt >> 2) + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      prog_words    <= '0;
      prog_overflow <= 1'b0;
      exec_go       <= 1'b0;
    end else begin
      exec_go <= 1'b0;
      if (finish_i && !wr_en) begin
        prog_words <= words_now;
        if (words_now > CNT_W'(CAP_WORDS)) begin
          prog_overflow <= 1'b1;
        end else begin
          prog_overflow <= 1'b0;
          exec_go       <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/regseq_encoder_chk.sv
module regseq_encoder_chk #(
  parameter int CAP_WORDS = 64,
  localparam int CNT_W = $clog2(4 * CAP_WORDS) + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             req_valid,
  input logic             req_ready,
  input logic             finish_i,
  input logic [CNT_W-1:0] prog_words,
  input logic             exec_go,
  input logic             prog_overflow
);
  // R10: an accepted request always blocks the next cycle
  a_r10_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !clear_i) |=> !req_ready);

  // R8: a go pulse only for a fitting program
  a_r8_go_fits: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> (prog_words <= CNT_W'(CAP_WORDS) && !prog_overflow));

  // R8: a go pulse is caused by a finish request
  a_r8_go_from_finish: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> $past(finish_i));

  // R9: overflow only with a word count above capacity
  a_r9_over_count: assert property (@(posedge clk) disable iff (!rst_n)
    prog_overflow |-> prog_words > CNT_W'(CAP_WORDS));

  // R1: clear returns the status to its empty state
  a_r1_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (prog_words == '0 && !prog_overflow && !exec_go));
endmodule

bind regseq_encoder regseq_encoder_chk #(.CAP_WORDS(CAP_WORDS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clear_i       (clear_i),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .finish_i      (finish_i),
  .prog_words    (prog_words),
  .exec_go       (exec_go),
  .prog_overflow (prog_overflow)
);

// File: tb/regseq_encoder_bench.sv
module regseq_encoder_bench;
  localparam int CAP   = 8;
  localparam int NB    = 4 * CAP;
  localparam int WW    = $clog2(CAP);
  localparam int CW    = $clog2(NB) + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear_i = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [31:0]   req_addr = '0;
  logic [31:0]   req_data = '0;
  logic [7:0]    req_flag = '0;
  logic [7:0]    req_val = '0;
  logic          finish_i = 1'b0;
  logic [WW-1:0] rd_idx = '0;
  logic [31:0]   rd_word;
  logic [CW-1:0] prog_words;
  logic          exec_go;
  logic          prog_overflow;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_b [NB];
  int exp_n = 0;

  always #10 clk = ~clk;

  regseq_encoder #(.CAP_WORDS(CAP)) u_regseq_encoder (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .req_flag(req_flag), .req_val(req_val),
    .finish_i(finish_i), .rd_idx(rd_idx), .rd_word(rd_word),
    .prog_words(prog_words), .exec_go(exec_go), .prog_overflow(prog_overflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic exp_reset();
    for (int i = 0; i < NB; i++) exp_b[i] = 8'h7F;
    exp_n = 0;
  endtask

  task automatic push(input logic [7:0] b);
    if (exp_n < NB) exp_b[exp_n] = b;
    exp_n++;
  endtask

  // Sends one request, returns the number of cycles req_ready stayed low after.
  task automatic send(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d,
                      input logic [7:0] f, input logic [7:0] v, output int stall);
    req_kind = k; req_addr = a; req_data = d; req_flag = f; req_val = v;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    stall = 0;
    while (!req_ready) begin
      stall++;
      @(negedge clk);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    exp_reset();
  endtask

  task automatic check_buffer(input string req);
    for (int w = 0; w < CAP; w++) begin
      rd_idx = WW'(w);
      #1;
      check(req, rd_word, {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]});
    end
  endtask

  task automatic do_finish(input string req);
    int words;
    words = (exp_n + 4) / 4;
    @(negedge clk); finish_i = 1'b1;
    @(negedge clk); finish_i = 1'b0;
    check({req, " words"}, 32'(prog_words), 32'(words));
    if (words <= CAP) begin
      check({req, " go"}, 32'(exec_go), 32'd1);
      check({req, " no overflow"}, 32'(prog_overflow), 32'd0);
      @(negedge clk);
      check({req, " go one cycle"}, 32'(exec_go), 32'd0);
    end else begin
      check({req, " R9 no go"}, 32'(exec_go), 32'd0);
      check({req, " R9 overflow"}, 32'(prog_overflow), 32'd1);
    end
  endtask

  task automatic t_reset();
    check("R1 ready after reset", 32'(req_ready), 32'd1);
    check("R1 words after reset", 32'(prog_words), 32'd0);
    check("R1 overflow after reset", 32'(prog_overflow), 32'd0);
    check_buffer("R1 fill after reset");
  endtask

  task automatic t_writes();
    int st;
    // first write: long data then long address
    send(2'd0, 32'h0000_1004, 32'h1234_5678, 8'h0, 8'h0, st);
    check("R10 stall of 10-byte write", 32'(st), 32'd10);
    push(8'hE2); push(8'h78); push(8'h56); push(8'h34); push(8'h12);
    push(8'hE0); push(8'h04); push(8'h10); push(8'h00); push(8'h00);
    // same upper halves: short forms
    send(2'd0, 32'h0000_1008, 32'h1234_9ABC, 8'h0, 8'h0, st);
    check("R10 stall of 6-byte write", 32'(st), 32'd6);
    push(8'h42); push(8'hBC); push(8'h9A);
    push(8'h40); push(8'h08); push(8'h10);
    // repeated data: data command elided (R2)
    send(2'd0, 32'h0000_100C, 32'h1234_9ABC, 8'h0, 8'h0, st);
    check("R2 elided data stall", 32'(st), 32'd3);
    push(8'h40); push(8'h0C); push(8'h10);
  endtask

  task automatic t_flags();
    int st;
    send(2'd1, 0, 0, 8'd3, 8'hFF, st); push(8'h83);
    check("R4 setf one byte", 32'(st), 32'd1);
    send(2'd1, 0, 0, 8'd3, 8'h00, st); push(8'hA3);
    send(2'd1, 0, 0, 8'd3, 8'h01, st); push(8'hC3);
    send(2'd2, 0, 0, 8'd5, 8'h01, st); push(8'h5F); push(8'h05); push(8'h01);
    check("R5 wait three bytes", 32'(st), 32'd3);
  endtask

  task automatic t_delays();
    int st;
    send(2'd3, 0, 32'd2500, 0, 0, st);   push(8'h02);
    send(2'd3, 0, 32'd20000, 0, 0, st);  push(8'h09);
    // 300 us truncates to 44 in 8 bits -> 0x0A (untruncated would give 0x11)
    send(2'd3, 0, 32'd300000, 0, 0, st); push(8'h0A);
    check("R6 delay one byte", 32'(st), 32'd1);
  endtask

  task automatic t_fit();
    check_buffer("R2 R3 R4 R5 R6 R7 program bytes");
    do_finish("R8 28-byte program");
  endtask

  task automatic t_boundary();
    int st;
    do_clear();
    check("R1 words after clear", 32'(prog_words), 32'd0);
    check_buffer("R1 fill after clear");
    // after clear the remembered values are all ones again: long forms
    send(2'd0, 32'h0000_1004, 32'h1234_5678, 0, 0, st);
    check("R1 long forms after clear", 32'(st), 32'd10);
    push(8'hE2); push(8'h78); push(8'h56); push(8'h34); push(8'h12);
    push(8'hE0); push(8'h04); push(8'h10); push(8'h00); push(8'h00);
    send(2'd0, 32'hAB00_0000, 32'h5555_0000, 0, 0, st);
    push(8'hE2); push(8'h00); push(8'h00); push(8'h55); push(8'h55);
    push(8'hE0); push(8'h00); push(8'h00); push(8'h00); push(8'hAB);
    send(2'd0, 32'h0000_0000, 32'h0000_0001, 0, 0, st);
    push(8'hE2); push(8'h01); push(8'h00); push(8'h00); push(8'h00);
    push(8'hE0); push(8'h00); push(8'h00); push(8'h00); push(8'h00);
    send(2'd3, 0, 32'd1000, 0, 0, st); push(8'h01);
    check_buffer("R7 31-byte buffer");
    do_finish("R8 31 bytes fit");
    send(2'd3, 0, 32'd1000, 0, 0, st); push(8'h01);
    do_finish("R9 32 bytes");
    send(2'd2, 0, 0, 8'd7, 8'd0, st); push(8'h5F); push(8'h07); push(8'h00);
    check_buffer("R9 excess bytes not stored");
    do_finish("R9 35 bytes");
  endtask

  initial begin
    exp_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_flags();
    t_delays();
    t_fit();
    t_boundary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule